// File: doc/BRIEF.md
# Serial memory write master with acknowledge polling

This block drives a two-wire serial bus as its only master to store one byte in a small serial memory. A client hands it a word address and a data byte over a valid/ready handshake. The block then sends the full write transaction: Start, write control byte, address, data and Stop. The Stop launches the memory's self-timed programming cycle.

During that cycle the memory stays silent. The block therefore keeps sending a Start followed by the write control byte, and the first acknowledge tells it that programming has finished. Between failed attempts it closes the bus with a Stop and holds the bus free for a set number of clock periods. A successful poll is also closed with a Stop. Only then does the block pulse `done_o`. If the target refuses a byte of the write itself, the block reports a refusal error. If polling never succeeds within a set number of attempts, it reports a timeout.

SCL is derived from the system clock: one SCL period lasts four quarter-periods of `CLK_DIV` system cycles each. SDA is open drain. The block only ever pulls it low or releases it.

Top module: `wpm_write_poll_master`

## Requirements
- R1: After reset `scl_o` is 1, `sda_oe_o` is 0 (SDA released), `cmd_ready_o` is 1 and `done_o`, `nack_err_o` and `timeout_err_o` are 0.
- R2: An accepted command is sent as Start, then three bytes MSB first (the control byte `{DEV_CODE, 3'b000, 1'b0}` = 0xA0 by default, then the address byte, then the data byte), each followed by a ninth clock, then Stop. Every control byte on the bus carries 000 in bits 3:1 and 0 in bit 0.
- R3: SDA changes only while SCL is low, except that it falls while SCL is high exactly once per Start and rises while SCL is high exactly once per Stop. A transaction with k polls shows k+1 Starts and k+1 Stops.
- R4: The master releases SDA for the whole ninth clock of every byte.
- R5: After the write Stop, the master sends a poll (Start plus control byte) immediately, with no gap. It repeats polls until one is acknowledged. With N refused polls and N < MAX_POLLS, exactly N+1 polls are sent.
- R6: After a refused poll that is not the last allowed one, the master sends Stop and then holds both lines high for at least GAP_PERIODS SCL periods (4·GAP_PERIODS·CLK_DIV system cycles) before the next Start.
- R7: After an acknowledged poll the master sends Stop, and then pulses `done_o` for one cycle with both error flags low. At that moment SCL is high and SDA is released. `done_o` rises 4·CLK_DIV·(29 + (A−1)·(11+GAP_PERIODS) + 11) cycles after the acceptance edge, where A is the number of polls.
- R8: A refusal of the write's control, address or data byte ends the transaction with a Stop and a `done_o` pulse with `nack_err_o`=1. No poll is sent. `done_o` rises 4·CLK_DIV·11, ·20 or ·29 cycles after acceptance respectively, and the target sees no completed write.
- R9: If MAX_POLLS polls are all refused, the master sends Stop and pulses `done_o` with `timeout_err_o`=1. The latency is the R7 formula with A = MAX_POLLS.
- R10: `cmd_ready_o` is low from the acceptance edge until `done_o`. A `cmd_valid_i` raised in that interval, with other address and data, has no effect on the bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken on valid and ready |
| cmd_addr_i | input | 8 | Word address to write |
| cmd_data_i | input | 8 | Data byte to write |
| scl_o | output | 1 | Serial clock level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle end-of-command pulse |
| nack_err_o | output | 1 | With `done_o`: target refused a write byte |
| timeout_err_o | output | 1 | With `done_o`: poll limit reached |

## Verification
Every result has a fixed cycle position, because each bus operation begins on the edge at which the previous one ends. The bench counts system-clock edges from the acceptance edge and requires `done_o` to appear exactly 4·CLK_DIV times the number of SCL periods that R7, R8 or R9 predict for the chosen number of refusals. A target model samples the bus on falling clock edges and changes its own SDA drive only there. The Start-to-Stop gap, the per-byte contents and the released ninth clocks are therefore measured in whole cycles, away from the edges at which the design updates. Each transaction is checked after `done_o`, against counts derived from the refusal number alone.

// File: rtl/wpm_pkg.sv
`timescale 1ns/1ps
package wpm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE, OP_IDLE} bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_W_START, S_W_CTRL, S_W_ADDR, S_W_DATA,
    S_STOP, S_GAP, S_P_START, S_P_CTRL
  } seq_state_e;

  typedef enum logic [2:0] {NX_POLL, NX_OK, NX_GAP, NX_NACK, NX_TMO} stop_next_e;
endpackage

// File: rtl/wpm_qtick.sv
`timescale 1ns/1ps
module wpm_qtick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R7
    end
  endgenerate
endmodule

// File: rtl/wpm_bit_engine.sv
`timescale 1ns/1ps
module wpm_bit_engine
  import wpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  bus_op_e           op_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              tick_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              ack_o,
  output logic              scl_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  bus_op_e           op_q;
  logic              busy_q, rx_q, scl_q, oe_q;
  logic [1:0]        ph_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              last;
  logic              cur_low, nxt_low;

  // returns {scl, sda pull-down}
  function automatic logic [1:0] drive(bus_op_e op, logic [1:0] ph, logic low);
    logic [1:0] r;
    case (op)
      OP_START: r = (ph == 2'd0) ? 2'b10 : (ph == 2'd3) ? 2'b01 : 2'b11;
      OP_STOP:  r = (ph == 2'd0) ? 2'b01 : (ph == 2'd3) ? 2'b10 : 2'b11;
      OP_BYTE:  r = {(ph == 2'd1) || (ph == 2'd2), low};
      default:  r = 2'b10;
    endcase
    return r;
  endfunction

  assign last    = (op_q != OP_BYTE) || (bit_q == ACK_SLOT);
  assign fin_o   = busy_q && tick_i && (ph_q == 2'd3) && last;
  assign cur_low = (bit_q != ACK_SLOT) && !sh_q[BYTE_W-1];
  assign nxt_low = ((bit_q + 1'b1) != ACK_SLOT) && !sh_q[BYTE_W-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= 1'b1;
      scl_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else if (go_i) begin
      busy_q         <= 1'b1;
      op_q           <= op_i;
      ph_q           <= 2'd0;
      bit_q          <= '0;
      sh_q           <= byte_i;
      {scl_q, oe_q}  <= drive(op_i, 2'd0, !byte_i[BYTE_W-1]);
    end else if (busy_q && tick_i) begin
      if (ph_q == 2'd1) rx_q <= sda_i;  // sampled a quarter after SCL rises
      if (ph_q == 2'd3) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          ph_q          <= 2'd0;
          bit_q         <= bit_q + 1'b1;
          sh_q          <= {sh_q[BYTE_W-2:0], 1'b0};
          {scl_q, oe_q} <= drive(op_q, 2'd0, nxt_low);
        end
      end else begin
        ph_q          <= ph_q + 2'd1;
        {scl_q, oe_q} <= drive(op_q, ph_q + 2'd1, cur_low);
      end
    end
  end

  assign busy_o   = busy_q;
  assign ack_o    = !rx_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = oe_q;

  AST_DATA_HELD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op_q == OP_BYTE && scl_q && $past(scl_q) && $past(busy_q && op_q == OP_BYTE))
    |-> $stable(oe_q)); // R3
  AST_NINTH_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op_q == OP_BYTE && bit_q == ACK_SLOT) |-> !oe_q); // R4
endmodule

// File: rtl/wpm_sequencer.sv
`timescale 1ns/1ps
module wpm_sequencer
  import wpm_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         MAX_POLLS   = 64,
  parameter int         GAP_PERIODS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              fin_i,
  input  logic              ack_i,
  input  logic              busy_i,
  output logic              cmd_ready_o,
  output logic              go_o,
  output bus_op_e           op_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o,
  output logic              nack_err_o,
  output logic              tmo_err_o
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(GAP_PERIODS + 1);
  localparam logic [BYTE_W-1:0] CTRL_WR = {DEV_CODE, 3'b000, 1'b0};

  seq_state_e        st_q, st_d;
  stop_next_e        nx_q, nx_d;
  logic [PW-1:0]     polls_q, polls_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic [BYTE_W-1:0] addr_q, data_q;
  logic              latch;
  logic              done_q, done_d, nack_q, nack_d, tmo_q, tmo_d;

  always_comb begin
    st_d    = st_q;
    nx_d    = nx_q;
    polls_d = polls_q;
    gap_d   = gap_q;
    go_o    = 1'b0;
    op_o    = OP_IDLE;
    byte_o  = CTRL_WR;
    latch   = 1'b0;
    done_d  = 1'b0;
    nack_d  = 1'b0;
    tmo_d   = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid_i) begin
        latch = 1'b1; go_o = 1'b1; op_o = OP_START; st_d = S_W_START;
      end
      S_W_START: if (fin_i) begin
        go_o = 1'b1; op_o = OP_BYTE; st_d = S_W_CTRL;
      end
      S_W_CTRL: if (fin_i) begin
        go_o = 1'b1;
        if (ack_i) begin op_o = OP_BYTE; byte_o = addr_q; st_d = S_W_ADDR; end
        else begin op_o = OP_STOP; nx_d = NX_NACK; st_d = S_STOP; end
      end
      S_W_ADDR: if (fin_i) begin
        go_o = 1'b1;
        if (ack_i) begin op_o = OP_BYTE; byte_o = data_q; st_d = S_W_DATA; end
        else begin op_o = OP_STOP; nx_d = NX_NACK; st_d = S_STOP; end
      end
      S_W_DATA: if (fin_i) begin
        go_o = 1'b1; op_o = OP_STOP; st_d = S_STOP;
        nx_d = ack_i ? NX_POLL : NX_NACK;
      end
      S_STOP: if (fin_i) begin
        case (nx_q)
          NX_POLL: begin go_o = 1'b1; op_o = OP_START; polls_d = '0; st_d = S_P_START; end
          NX_GAP:  begin go_o = 1'b1; op_o = OP_IDLE; gap_d = GW'(GAP_PERIODS - 1); st_d = S_GAP; end
          NX_OK:   begin done_d = 1'b1; st_d = S_IDLE; end
          NX_NACK: begin done_d = 1'b1; nack_d = 1'b1; st_d = S_IDLE; end
          default: begin done_d = 1'b1; tmo_d = 1'b1; st_d = S_IDLE; end
        endcase
      end
      S_GAP: if (fin_i) begin
        go_o = 1'b1;
        if (gap_q == '0) begin op_o = OP_START; st_d = S_P_START; end
        else begin op_o = OP_IDLE; gap_d = gap_q - 1'b1; end
      end
      S_P_START: if (fin_i) begin
        go_o = 1'b1; op_o = OP_BYTE; polls_d = polls_q + 1'b1; st_d = S_P_CTRL;
      end
      S_P_CTRL: if (fin_i) begin
        go_o = 1'b1; op_o = OP_STOP; st_d = S_STOP;
        if (ack_i)                              nx_d = NX_OK;
        else if (polls_q == PW'(MAX_POLLS))     nx_d = NX_TMO;
        else                                    nx_d = NX_GAP;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      nx_q    <= NX_OK;
      polls_q <= '0;
      gap_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      nack_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      nx_q    <= nx_d;
      polls_q <= polls_d;
      gap_q   <= gap_d;
      done_q  <= done_d;
      nack_q  <= nack_d;
      tmo_q   <= tmo_d;
      if (latch) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign cmd_ready_o = (st_q == S_IDLE);
  assign done_o      = done_q;
  assign nack_err_o  = nack_q;
  assign tmo_err_o   = tmo_q;

  AST_POLL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q <= PW'(MAX_POLLS)); // R9
  AST_GO_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (!busy_i || fin_i)); // R3
  AST_SINGLE_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !(nack_q && tmo_q)); // R8
endmodule

// File: rtl/wpm_write_poll_master.sv
`timescale 1ns/1ps
module wpm_write_poll_master #(
  parameter int         CLK_DIV     = 125,
  parameter int         MAX_POLLS   = 64,
  parameter int         GAP_PERIODS = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [7:0] cmd_addr_i,
  input  logic [7:0] cmd_data_i,
  output logic       scl_o,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       nack_err_o,
  output logic       timeout_err_o
);
  import wpm_pkg::*;

  logic              busy, tick, fin, ack, go;
  bus_op_e           op;
  logic [BYTE_W-1:0] tx_byte;

  wpm_qtick #(.DIV(CLK_DIV)) i_qtick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  wpm_bit_engine i_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .op_i     (op),
    .byte_i   (tx_byte),
    .tick_i   (tick),
    .sda_i    (sda_i),
    .busy_o   (busy),
    .fin_o    (fin),
    .ack_o    (ack),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o)
  );

  wpm_sequencer #(
    .DEV_CODE    (DEV_CODE),
    .MAX_POLLS   (MAX_POLLS),
    .GAP_PERIODS (GAP_PERIODS)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .addr_i      (cmd_addr_i),
    .data_i      (cmd_data_i),
    .fin_i       (fin),
    .ack_i       (ack),
    .busy_i      (busy),
    .cmd_ready_o (cmd_ready_o),
    .go_o        (go),
    .op_o        (op),
    .byte_o      (tx_byte),
    .done_o      (done_o),
    .nack_err_o  (nack_err_o),
    .tmo_err_o   (timeout_err_o)
  );

  AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scl_o && !sda_oe_o)); // R7
  AST_READY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !busy); // R10
  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_err_o || timeout_err_o) |-> done_o); // R9
endmodule

// File: tb/test_wpm_write_poll_master.sv
`timescale 1ns/1ps
module test_wpm_write_poll_master;
  localparam int D = 2;
  localparam int P = 3;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_data = '0;
  logic       cmd_ready, scl, sda_oe, done, nack_err, tmo_err;
  logic       slave_pull = 1'b0;
  wire        sda_line = !(sda_oe || slave_pull);

  wpm_write_poll_master #(.CLK_DIV(D), .MAX_POLLS(P), .GAP_PERIODS(G)) i_wpm_write_poll_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .scl_o(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .done_o(done), .nack_err_o(nack_err), .timeout_err_o(tmo_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  // target model state
  int knob_busy = 0, knob_nack = 0, busy_left = 0;
  int n_starts = 0, n_stops = 0, n_writes = 0, bitn = 0, bytes_seen = 0, acked = 0;
  int ctrl_bad = 0, ninth_bad = 0, gap_bad = 0, gap_seen = 0, t_stop = 0;
  logic [7:0] sh = '0, cap_addr = '0, cap_data = '0, got_addr = '0, got_data = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, poll_nacked = 1'b0, expect_gap = 1'b0;

  initial begin
    forever begin
      logic s, d, ackb;
      @(negedge clk);
      s = scl; d = sda_line;
      if (prev_scl && s && prev_sda && !d) begin
        n_starts++; bitn = 0; bytes_seen = 0; acked = 0; slave_pull = 1'b0;
        if (expect_gap) begin
          gap_seen++;
          if (cyc - t_stop < 4 * G * D) gap_bad++;
          expect_gap = 1'b0;
        end
      end else if (prev_scl && s && !prev_sda && d) begin
        n_stops++;
        if (acked == 3) begin
          n_writes++; got_addr = cap_addr; got_data = cap_data; busy_left = knob_busy;
        end
        acked = 0;
        if (poll_nacked) begin expect_gap = 1'b1; t_stop = cyc; poll_nacked = 1'b0; end
      end else if (!prev_scl && s) begin
        if (bitn < 8) sh = {sh[6:0], d};
        else if (bitn == 8 && sda_oe) ninth_bad++;
        bitn++;
      end else if (prev_scl && !s) begin
        if (bitn == 8) begin
          ackb = 1'b1;
          if (bytes_seen == 0) begin
            if (sh != 8'hA0) ctrl_bad++;
            if (busy_left > 0) begin ackb = 1'b0; busy_left--; poll_nacked = 1'b1; end
            else if (knob_nack == 1) ackb = 1'b0;
          end else if (bytes_seen == 1) begin
            cap_addr = sh; ackb = (knob_nack != 2);
          end else begin
            cap_data = sh; ackb = (knob_nack != 3);
          end
          if (ackb) acked++;
          slave_pull = ackb;
        end else if (bitn == 9) begin
          slave_pull = 1'b0; bitn = 0; bytes_seen++;
        end
      end
      prev_scl = s; prev_sda = d;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] addr, input logic [7:0] data,
                     input int nbusy, input int nack_at, input bit extra);
    int a, dn, wd, attempts, periods, exp_writes;
    bit exp_nack, exp_tmo;
    knob_busy = nbusy; knob_nack = nack_at; busy_left = 0;
    n_starts = 0; n_stops = 0; n_writes = 0; ctrl_bad = 0; ninth_bad = 0;
    gap_bad = 0; gap_seen = 0; expect_gap = 1'b0; poll_nacked = 1'b0;
    @(negedge clk);
    cmd_addr = addr; cmd_data = data; cmd_valid = 1'b1;
    @(negedge clk);
    a = cyc;
    chk(!cmd_ready, "R10 ready low after accept", cmd_ready, 0);
    if (extra) begin
      cmd_addr = ~addr; cmd_data = ~data;
      for (int i = 0; i < 12; i++) @(negedge clk);
      chk(!cmd_ready && !done, "R10 ready low while busy", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    dn = cyc;
    chk(wd < 20000, "R7 done reached", wd, 20000);

    exp_nack = (nack_at != 0);
    exp_tmo  = !exp_nack && (nbusy >= P);
    attempts = exp_nack ? 0 : ((nbusy + 1 < P) ? nbusy + 1 : P);
    if (nack_at == 1)      periods = 11;
    else if (nack_at == 2) periods = 20;
    else if (nack_at == 3) periods = 29;
    else                   periods = 29 + (attempts - 1) * (11 + G) + 11;
    exp_writes = exp_nack ? 0 : 1;

    chk(nack_err == exp_nack, "R8 refusal flag", nack_err, exp_nack);
    chk(tmo_err == exp_tmo, "R9 timeout flag", tmo_err, exp_tmo);
    chk(dn - a == periods * 4 * D, "R7 done latency", dn - a, periods * 4 * D);
    chk(scl && !sda_oe, "R7 bus idle at done", {scl, sda_oe}, 2);
    chk(n_writes == exp_writes, "R2 completed writes", n_writes, exp_writes);
    if (exp_writes == 1) begin
      chk(got_addr == addr, "R2 address byte", got_addr, addr);
      chk(got_data == data, "R2 data byte", got_data, data);
    end
    chk(ctrl_bad == 0, "R2 control byte 0xA0", ctrl_bad, 0);
    chk(ninth_bad == 0, "R4 ninth clock released", ninth_bad, 0);
    chk(n_starts == 1 + attempts, "R5 start count", n_starts, 1 + attempts);
    chk(n_stops == 1 + attempts, "R3 stop count", n_stops, 1 + attempts);
    chk(gap_seen == ((attempts > 1) ? attempts - 1 : 0), "R6 gaps seen", gap_seen,
        (attempts > 1) ? attempts - 1 : 0);
    chk(gap_bad == 0, "R6 bus-free gap length", gap_bad, 0);
    @(negedge clk);
    chk(!done && cmd_ready, "R7 single done pulse", done, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scl == 1'b1 && sda_oe == 1'b0, "R1 bus idle in reset", {scl, sda_oe}, 2);
    chk(cmd_ready && !done && !nack_err && !tmo_err, "R1 status in reset",
        {cmd_ready, done, nack_err, tmo_err}, 8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl == 1'b1 && sda_oe == 1'b0 && cmd_ready, "R1 idle after reset",
        {scl, sda_oe, cmd_ready}, 5);
    for (int n = 0; n <= P + 1; n++) begin
      run(8'(8'h13 * (n + 1)), 8'(8'hA5 ^ (n * 8'h3C)), n, 0, 1'b0);
      run(8'(8'hF0 - n), 8'(8'h01 << n), n, 0, 1'b0);
    end
    for (int k = 1; k <= 3; k++) run(8'(8'h40 + k), 8'(8'h7E - k), 0, k, 1'b0);
    run(8'h0F, 8'hC3, 1, 0, 1'b1);
    run(8'h00, 8'hFF, 0, 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule